// File: doc/BRIEF.md
# Integer ALU with product, remainder and flags

A purely combinational integer arithmetic unit for a simple processor datapath. Two operands, A and B, and a 4-bit operation code produce a primary result, a secondary result, a signed-overflow flag and an equality flag, all in the same cycle. The operations are shifts, a signed multiply, an unsigned divide, trapping and non-trapping add and subtract, bitwise logic, and signed and unsigned set-less-than.

For the shift operations, A supplies the shift amount and B is the value that is shifted. The secondary result carries the upper half of the double-width signed product or the division remainder. For every other code it is driven to zero, so no output is ever left undefined. The execute stage of the surrounding core uses the overflow flag to raise a trap. The branch logic uses the equality flag.

Top module: `int_alu`

## Requirements
- R1: Codes 0, 1 and 2 shift B left logically, right logically and right arithmetically. The shift amount is the low log2(WIDTH) bits of A, which is 5 bits at the default width. The upper bits of A are ignored.
- R2: Code 3 multiplies A and B as signed values. The low WIDTH bits of the 2*WIDTH-bit product go to res_o and the high WIDTH bits go to res_hi_o.
- R3: Code 4 divides A by B as unsigned values, with the quotient on res_o and the remainder on res_hi_o. When B is zero, both results are zero.
- R4: Codes 5 and 6 output A+B modulo 2^WIDTH. Only code 5 raises ovf_o, and it does so exactly when the true signed sum lies outside the signed range.
- R5: Codes 7 and 8 output A-B modulo 2^WIDTH. Only code 7 raises ovf_o, and it does so exactly when the true signed difference lies outside the signed range.
- R6: Codes 9, 10, 11 and 12 output the bitwise AND, OR, XOR and NOR of A and B.
- R7: Code 13 outputs 1 when A<B as signed values and 0 otherwise. Code 14 makes the same comparison on unsigned values.
- R8: eq_o is high exactly when A equals B, for every operation code.
- R9: res_hi_o is zero for all codes other than 3 and 4. ovf_o is low for all codes other than 5 and 7. Code 15 gives zero on res_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | WIDTH | Operand A; shift amount for shifts |
| opb_i | input | WIDTH | Operand B; shifted value for shifts |
| op_i | input | 4 | Operation code |
| res_o | output | WIDTH | Primary result |
| res_hi_o | output | WIDTH | Product high half or remainder, else zero |
| ovf_o | output | 1 | Signed overflow of codes 5 and 7 |
| eq_o | output | 1 | A equals B |

## Verification
The bench works on an 8-bit instance. All 16 codes run against every B value, paired with sixteen A values. The A values include zero, one, the signed extremes around 0x7F/0x80, all-ones and alternating bit patterns. The signed extremes separate the trapping forms from the non-trapping ones, and they show whether the signed and unsigned compares differ. A zero B checks the divide-by-zero rule. A values above 7 show whether the shifter ignores the upper bits of A. Because B takes every value, each A also meets an equal B, so eq_o is seen both high and low under every code.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [3:0] {
    OP_SLL  = 4'd0,
    OP_SRL  = 4'd1,
    OP_SRA  = 4'd2,
    OP_MUL  = 4'd3,
    OP_DIVU = 4'd4,
    OP_ADD  = 4'd5,
    OP_ADDU = 4'd6,
    OP_SUB  = 4'd7,
    OP_SUBU = 4'd8,
    OP_AND  = 4'd9,
    OP_OR   = 4'd10,
    OP_XOR  = 4'd11,
    OP_NOR  = 4'd12,
    OP_SLT  = 4'd13,
    OP_SLTU = 4'd14,
    OP_NONE = 4'd15
  } alu_op_e;
endpackage

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] amt_i,
  input  logic [WIDTH-1:0] val_i,
  output logic [WIDTH-1:0] sll_o,
  output logic [WIDTH-1:0] srl_o,
  output logic [WIDTH-1:0] sra_o
);
  localparam int ShW = $clog2(WIDTH);

  logic [ShW-1:0] sh;
  assign sh    = amt_i[ShW-1:0];
  assign sll_o = val_i << sh;
  assign srl_o = val_i >> sh;
  assign sra_o = $unsigned($signed(val_i) >>> sh);
endmodule

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             sum_ovf_o,
  output logic [WIDTH-1:0] diff_o,
  output logic             diff_ovf_o,
  output logic             lt_s_o,
  output logic             lt_u_o,
  output logic             zero_o
);
  logic [WIDTH:0] add_full, sub_full;
  logic           add_cmsb, sub_cmsb;
  logic [WIDTH-1:0] b_inv;

  assign b_inv    = ~b_i;
  assign add_full = {1'b0, a_i} + {1'b0, b_i};
  assign sub_full = {1'b0, a_i} + {1'b0, b_inv} + {{WIDTH{1'b0}}, 1'b1};

  // carry into msb recovered from sum bit and operand bits
  assign add_cmsb   = add_full[WIDTH-1] ^ a_i[WIDTH-1] ^ b_i[WIDTH-1];
  assign sub_cmsb   = sub_full[WIDTH-1] ^ a_i[WIDTH-1] ^ b_inv[WIDTH-1];
  assign sum_o      = add_full[WIDTH-1:0];
  assign diff_o     = sub_full[WIDTH-1:0];
  assign sum_ovf_o  = add_cmsb ^ add_full[WIDTH];
  assign diff_ovf_o = sub_cmsb ^ sub_full[WIDTH];
  assign lt_u_o     = ~sub_full[WIDTH];
  assign lt_s_o     = sub_full[WIDTH-1] ^ diff_ovf_o;
  assign zero_o     = ~|sub_full[WIDTH-1:0];
endmodule

// File: rtl/int_alu_muldiv.sv
module int_alu_muldiv #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] prod_lo_o,
  output logic [WIDTH-1:0] prod_hi_o,
  output logic [WIDTH-1:0] quot_o,
  output logic [WIDTH-1:0] rem_o
);
  localparam int PW = 2 * WIDTH;

  logic signed [PW-1:0] a_ext, b_ext, prod;
  logic                 div_zero;

  assign a_ext     = $signed({{WIDTH{a_i[WIDTH-1]}}, a_i});
  assign b_ext     = $signed({{WIDTH{b_i[WIDTH-1]}}, b_i});
  assign prod      = a_ext * b_ext;
  assign prod_lo_o = prod[WIDTH-1:0];
  assign prod_hi_o = prod[PW-1:WIDTH];

  assign div_zero = ~|b_i;
  assign quot_o   = div_zero ? '0 : a_i / b_i;
  assign rem_o    = div_zero ? '0 : a_i % b_i;
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [3:0]       op_i,
  output logic [WIDTH-1:0] res_o,
  output logic [WIDTH-1:0] res_hi_o,
  output logic             ovf_o,
  output logic             eq_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [WIDTH-1:0] sll_v, srl_v, sra_v;
  logic [WIDTH-1:0] sum_v, diff_v;
  logic             sum_ovf, diff_ovf, lt_s, lt_u, zero_v;
  logic [WIDTH-1:0] plo_v, phi_v, quot_v, rem_v;

  int_alu_shift #(.WIDTH(WIDTH)) u_shift (
    .amt_i(opa_i), .val_i(opb_i),
    .sll_o(sll_v), .srl_o(srl_v), .sra_o(sra_v)
  );

  int_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i(opa_i), .b_i(opb_i),
    .sum_o(sum_v), .sum_ovf_o(sum_ovf),
    .diff_o(diff_v), .diff_ovf_o(diff_ovf),
    .lt_s_o(lt_s), .lt_u_o(lt_u), .zero_o(zero_v)
  );

  int_alu_muldiv #(.WIDTH(WIDTH)) u_muldiv (
    .a_i(opa_i), .b_i(opb_i),
    .prod_lo_o(plo_v), .prod_hi_o(phi_v),
    .quot_o(quot_v), .rem_o(rem_v)
  );

  assign eq_o = zero_v;

  always_comb begin
    res_o    = '0;
    res_hi_o = '0;
    ovf_o    = 1'b0;
    unique case (op)
      OP_SLL:  res_o = sll_v;
      OP_SRL:  res_o = srl_v;
      OP_SRA:  res_o = sra_v;
      OP_MUL:  begin res_o = plo_v;  res_hi_o = phi_v; end
      OP_DIVU: begin res_o = quot_v; res_hi_o = rem_v; end
      OP_ADD:  begin res_o = sum_v;  ovf_o = sum_ovf;  end
      OP_ADDU: res_o = sum_v;
      OP_SUB:  begin res_o = diff_v; ovf_o = diff_ovf; end
      OP_SUBU: res_o = diff_v;
      OP_AND:  res_o = opa_i & opb_i;
      OP_OR:   res_o = opa_i | opb_i;
      OP_XOR:  res_o = opa_i ^ opb_i;
      OP_NOR:  res_o = ~(opa_i | opb_i);
      OP_SLT:  res_o = {{(WIDTH-1){1'b0}}, lt_s};
      OP_SLTU: res_o = {{(WIDTH-1){1'b0}}, lt_u};
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opa_i,
  input logic [WIDTH-1:0] opb_i,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] res_o,
  input logic [WIDTH-1:0] res_hi_o,
  input logic             ovf_o,
  input logic             eq_o
);
  logic known;
  assign known = !$isunknown({opa_i, opb_i, op_i});

  always_comb begin
    if (known) begin
      a_r8_eq: assert (eq_o == (opa_i == opb_i));
      a_r9_hi_zero: assert ((op_i == 4'd3) || (op_i == 4'd4) || (res_hi_o == '0));
      a_r9_ovf_scope: assert (!ovf_o || (op_i == 4'd5) || (op_i == 4'd7));
      a_r4_add_ovf: assert ((op_i != 4'd5) ||
        (ovf_o == ((opa_i[WIDTH-1] == opb_i[WIDTH-1]) && (res_o[WIDTH-1] != opa_i[WIDTH-1]))));
      a_r5_sub_ovf: assert ((op_i != 4'd7) ||
        (ovf_o == ((opa_i[WIDTH-1] != opb_i[WIDTH-1]) && (res_o[WIDTH-1] != opa_i[WIDTH-1]))));
      a_r7_slt: assert ((op_i != 4'd13) || (res_o == WIDTH'($signed(opa_i) < $signed(opb_i))));
      a_r7_sltu: assert ((op_i != 4'd14) || (res_o == WIDTH'(opa_i < opb_i)));
      a_r3_div_zero: assert ((op_i != 4'd4) || (opb_i != '0) || ((res_o == '0) && (res_hi_o == '0)));
    end
  end
endmodule

bind int_alu int_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .opa_i(opa_i), .opb_i(opb_i), .op_i(op_i),
  .res_o(res_o), .res_hi_o(res_hi_o), .ovf_o(ovf_o), .eq_o(eq_o)
);

// File: tb/tb_int_alu.sv
`timescale 1ns/100ps
module tb_int_alu;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] opa, opb, res, res_hi;
  logic [3:0]   op;
  logic         ovf, eq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int_alu #(.WIDTH(W)) dut (
    .opa_i(opa), .opb_i(opb), .op_i(op),
    .res_o(res), .res_hi_o(res_hi), .ovf_o(ovf), .eq_o(eq)
  );

  function automatic string req_of(input int code);
    case (code)
      0, 1, 2:           return "R1";
      3:                 return "R2";
      4:                 return "R3";
      5, 6:              return "R4";
      7, 8:              return "R5";
      9, 10, 11, 12:     return "R6";
      13, 14:            return "R7";
      default:           return "R9";
    endcase
  endfunction

  task automatic check_vec(input int code, input int a, input int b);
    int sa, sb, ua, ub, sh, t;
    int e_res, e_hi, e_ovf, e_eq;
    ua = a; ub = b;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    sh = ua % 8;
    e_hi = 0; e_ovf = 0; e_res = 0;
    e_eq = (ua == ub) ? 1 : 0;
    case (code)
      0: e_res = (ub << sh) & 255;
      1: e_res = ub >> sh;
      2: e_res = (sb >>> sh) & 255;
      3: begin t = sa * sb; e_res = t & 255; e_hi = (t >>> 8) & 255; end
      4: if (ub != 0) begin e_res = ua / ub; e_hi = ua % ub; end
      5, 6: begin
        t = sa + sb; e_res = (ua + ub) & 255;
        if (code == 5 && (t > 127 || t < -128)) e_ovf = 1;
      end
      7, 8: begin
        t = sa - sb; e_res = (ua - ub) & 255;
        if (code == 7 && (t > 127 || t < -128)) e_ovf = 1;
      end
      9:  e_res = ua & ub;
      10: e_res = ua | ub;
      11: e_res = ua ^ ub;
      12: e_res = (~(ua | ub)) & 255;
      13: e_res = (sa < sb) ? 1 : 0;
      14: e_res = (ua < ub) ? 1 : 0;
      default: e_res = 0;
    endcase
    opa = W'(a); opb = W'(b); op = 4'(code);
    #1;
    checks++;
    if (res !== W'(e_res) || res_hi !== W'(e_hi) || ovf !== e_ovf[0] || eq !== e_eq[0]) begin
      errors++;
      $display("FAIL %s (R8 eq, R9 hi/ovf) op=%0d a=%h b=%h: got res=%h hi=%h ovf=%b eq=%b, exp res=%h hi=%h ovf=%b eq=%b",
               req_of(code), code, a[7:0], b[7:0], res, res_hi, ovf, eq,
               e_res[7:0], e_hi[7:0], e_ovf[0], e_eq[0]);
    end
  endtask

  initial begin
    int a_set [16] = '{0, 1, 2, 3, 7, 8, 16, 64, 85, 127, 128, 129, 170, 195, 254, 255};
    opa = '0; opb = '0; op = 4'd0;
    #1;
    rst_ni = 1'b1;
    // reset-state style check: zero operands, code 0
    checks++;
    if (res !== '0 || res_hi !== '0 || ovf !== 1'b0 || eq !== 1'b1) begin
      errors++;
      $display("FAIL R8 idle: got res=%h hi=%h ovf=%b eq=%b, exp 00 00 0 1", res, res_hi, ovf, eq);
    end
    // R1..R9 sweep: every code, every B, sixteen A values
    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 16; i++)
        for (int b = 0; b < 256; b++)
          check_vec(c, a_set[i], b);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout, exp completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule